// File: doc/BRIEF.md
# Datapath Shift Stage with Selectable Shift-In

This block is the shift stage that follows the masked result of an 8-bit datapath ALU. It works on that result whatever the ALU did. A 2-bit operation code picks one of four actions: pass the value through, shift it left by one, shift it right by one, or swap its two nibbles. A static MSB position sets where the active word ends. A shift left takes its outgoing bit from that position. A shift right injects the incoming bit at that position. Bits above the MSB position still move, and whatever leaves that upper group is lost.

The incoming bit for a shift comes from one of four sources. Two static source codes, set A and set B, are held in configuration. A per-cycle select bit picks which set applies. The sources are:
- a static constant bit, or the ALU's selected MSB when the arithmetic option is set and the shift is to the right;
- the shift-out bit registered on an earlier cycle in the same direction;
- an external routed input;
- a chained input from a neighbouring datapath slice.

The left and right shift-out bits are produced every cycle. They are registered on every enabled cycle so that they can feed later cycles. One of them is routed to the single datapath shift output by a static select.

Top module: `shf_stage`

## Requirements
- R1: With operation code 00 (pass), `data_out` equals `data_in`.
- R2: With code 01 (shift left), `data_out` is `data_in` shifted up one place with the shift-in bit at bit 0, and the top bit of `data_in` is lost.
- R3: With code 10 (shift right), bit i of `data_out` is bit i+1 of `data_in`. The exception is bit `msb_pos` and the top bit: both take the shift-in bit.
- R4: For every operation, `sh_left_out` equals `data_in[msb_pos]` and `sh_right_out` equals `data_in[0]`.
- R5: When `cfg_sel` is 0, source code `si_src_a` applies; when it is 1, `si_src_b` applies.
- R6: Source code 00 supplies `def_si`. On a shift right with `msb_si_en` high, it supplies `data_in[msb_pos]` instead. `msb_si_en` has no effect on a shift left.
- R7: Source code 01 supplies `reg_left_out` to a shift left and `reg_right_out` to a shift right.
- R8: Source code 10 supplies the `si_ext` input.
- R9: Source code 11 supplies `chain_from_right` to a shift left and `chain_from_left` to a shift right.
- R10: With code 11 (nibble swap), `data_out` is `data_in` with its upper and lower halves exchanged, whatever the shift-in source.
- R11: `dp_shift_out` equals `sh_left_out` when `out_sel` is 1 and `sh_right_out` when `out_sel` is 0.
- R12: `reg_left_out` and `reg_right_out` are 0 after reset. On a rising edge with `en` high they take `sh_left_out` and `sh_right_out`. With `en` low they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Cycle enable for the registered shift-out bits |
| data_in | input | 8 | Masked ALU result |
| shift_op | input | 2 | Operation: 00 pass, 01 left, 10 right, 11 nibble swap |
| cfg_sel | input | 1 | Per-cycle choice of source set A (0) or B (1) |
| si_src_a | input | 2 | Shift-in source for set A: 00 default, 01 registered, 10 routed, 11 chained |
| si_src_b | input | 2 | Shift-in source for set B, same encoding |
| def_si | input | 1 | Static default shift-in constant |
| msb_si_en | input | 1 | Use the selected MSB as default shift-in on right shifts |
| msb_pos | input | 3 | Static MSB position |
| out_sel | input | 1 | Datapath shift output: 0 right shift-out, 1 left shift-out |
| si_ext | input | 1 | Routed external shift-in |
| chain_from_right | input | 1 | Chained shift-in for left shifts, from the slice on the right |
| chain_from_left | input | 1 | Chained shift-in for right shifts, from the slice on the left |
| data_out | output | 8 | Shifted result |
| sh_left_out | output | 1 | Current left shift-out bit |
| sh_right_out | output | 1 | Current right shift-out bit |
| dp_shift_out | output | 1 | Selected datapath shift output |
| reg_left_out | output | 1 | Registered left shift-out |
| reg_right_out | output | 1 | Registered right shift-out |

## Verification
`data_out`, both current shift-out bits and `dp_shift_out` are combinational. They are due in the same cycle as the stimulus. The bench applies inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. The registered shift-out bits are due one rising edge after an enabled cycle. The bench samples them 1 ns after that edge. A registered-source shift is then checked in a following cycle with `en` low, so the value it reads is known.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SH_PASS  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_SWAP  = 2'b11
    } sh_op_e;

    typedef enum logic [1:0] {
        SI_DEFAULT    = 2'b00,
        SI_REGISTERED = 2'b01,
        SI_ROUTED     = 2'b10,
        SI_CHAINED    = 2'b11
    } si_src_e;

    typedef struct packed {
        logic left;
        logic right;
    } shout_t;

    function automatic logic is_shift(input sh_op_e op);
        return (op == SH_LEFT) || (op == SH_RIGHT);
    endfunction

endpackage

// File: rtl/shf_si_sel.sv
module shf_si_sel
    import shf_pkg::*;
(
    input  sh_op_e  op,
    input  logic    cfg_sel,
    input  si_src_e src_a,
    input  si_src_e src_b,
    input  logic    def_si,
    input  logic    msb_si_en,
    input  logic    msb_bit,
    input  shout_t  reg_out,
    input  logic    si_ext,
    input  logic    chain_from_right,
    input  logic    chain_from_left,
    output logic    si_bit
);

    si_src_e src;
    logic    going_left;

    assign src        = cfg_sel ? src_b : src_a;
    assign going_left = (op == SH_LEFT);

    always_comb begin
        unique case (src)
            SI_DEFAULT:    si_bit = (op == SH_RIGHT && msb_si_en) ? msb_bit : def_si;
            SI_REGISTERED: si_bit = going_left ? reg_out.left : reg_out.right;
            SI_ROUTED:     si_bit = si_ext;
            SI_CHAINED:    si_bit = going_left ? chain_from_right : chain_from_left;
            default:       si_bit = def_si;
        endcase
    end

endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int W  = 8,
    parameter int MW = $clog2(W)
) (
    input  logic [W-1:0]  data_in,
    input  sh_op_e        op,
    input  logic [MW-1:0] msb_pos,
    input  logic          si_bit,
    output logic [W-1:0]  data_out,
    output shout_t        sh_out
);

    localparam int NIB = W / 2;

    logic [W-1:0] left_val;
    logic [W-1:0] right_val;
    logic [W-1:0] swap_val;

    assign left_val = {data_in[W-2:0], si_bit};
    assign swap_val = {data_in[NIB-1:0], data_in[W-1:NIB]};

    for (genvar i = 0; i < W; i++) begin : g_rs
        if (i == W - 1) begin : g_top
            assign right_val[i] = si_bit;
        end else begin : g_low
            assign right_val[i] = (msb_pos == MW'(i)) ? si_bit : data_in[i+1];
        end
    end

    always_comb begin
        unique case (op)
            SH_PASS:  data_out = data_in;
            SH_LEFT:  data_out = left_val;
            SH_RIGHT: data_out = right_val;
            SH_SWAP:  data_out = swap_val;
            default:  data_out = data_in;
        endcase
    end

    assign sh_out.left  = data_in[msb_pos];
    assign sh_out.right = data_in[0];

endmodule

// File: rtl/shf_outreg.sv
module shf_outreg
    import shf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  shout_t nxt,
    output shout_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= nxt;
        end
    end

    AST_REG_CLEARED: assert property (@(posedge clk) rst |=> (q == '0)); // R12
    AST_REG_HELD:    assert property (@(posedge clk) disable iff (rst)
                                      !en |=> $stable(q)); // R12

endmodule

// File: rtl/shf_stage.sv
module shf_stage
    import shf_pkg::*;
#(
    parameter int W  = 8,
    parameter int MW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [W-1:0]  data_in,
    input  logic [1:0]    shift_op,
    input  logic          cfg_sel,
    input  logic [1:0]    si_src_a,
    input  logic [1:0]    si_src_b,
    input  logic          def_si,
    input  logic          msb_si_en,
    input  logic [MW-1:0] msb_pos,
    input  logic          out_sel,
    input  logic          si_ext,
    input  logic          chain_from_right,
    input  logic          chain_from_left,
    output logic [W-1:0]  data_out,
    output logic          sh_left_out,
    output logic          sh_right_out,
    output logic          dp_shift_out,
    output logic          reg_left_out,
    output logic          reg_right_out
);

    localparam int NIB = W / 2;

    sh_op_e op;
    shout_t cur_out;
    shout_t reg_out;
    logic   si_bit;

    assign op = sh_op_e'(shift_op);

    shf_si_sel u_si_sel (
        .op               (op),
        .cfg_sel          (cfg_sel),
        .src_a            (si_src_e'(si_src_a)),
        .src_b            (si_src_e'(si_src_b)),
        .def_si           (def_si),
        .msb_si_en        (msb_si_en),
        .msb_bit          (cur_out.left),
        .reg_out          (reg_out),
        .si_ext           (si_ext),
        .chain_from_right (chain_from_right),
        .chain_from_left  (chain_from_left),
        .si_bit           (si_bit)
    );

    shf_core #(.W(W), .MW(MW)) u_core (
        .data_in  (data_in),
        .op       (op),
        .msb_pos  (msb_pos),
        .si_bit   (si_bit),
        .data_out (data_out),
        .sh_out   (cur_out)
    );

    shf_outreg u_outreg (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .nxt (cur_out),
        .q   (reg_out)
    );

    assign sh_left_out   = cur_out.left;
    assign sh_right_out  = cur_out.right;
    assign dp_shift_out  = out_sel ? cur_out.left : cur_out.right;
    assign reg_left_out  = reg_out.left;
    assign reg_right_out = reg_out.right;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (shift_op == 2'b00) |-> (data_out == data_in)); // R1
    AST_LEFT_BODY:    assert property (@(posedge clk) disable iff (rst)
        (shift_op == 2'b01) |-> (data_out[W-1:1] == data_in[W-2:0])); // R2
    AST_RIGHT_LSB:    assert property (@(posedge clk) disable iff (rst)
        (shift_op == 2'b10) |-> (sh_right_out == data_in[0])); // R4
    AST_SWAP_NO_SI:   assert property (@(posedge clk) disable iff (rst)
        (shift_op == 2'b11) |-> (data_out == {data_in[NIB-1:0], data_in[W-1:NIB]})); // R10
    AST_REG_UPDATE:   assert property (@(posedge clk) disable iff (rst)
        en |=> (reg_left_out == $past(data_in[msb_pos]))); // R12

endmodule

// File: tb/shf_stage_tb.sv
`timescale 1ns/1ps
module shf_stage_tb;

    logic       clk = 1'b0;
    logic       rst, en, cfg_sel, def_si, msb_si_en, out_sel, si_ext, cfr, cfl;
    logic [7:0] data_in;
    logic [1:0] shift_op, si_src_a, si_src_b;
    logic [2:0] msb_pos;
    logic [7:0] data_out;
    logic       sh_left_out, sh_right_out, dp_shift_out, reg_left_out, reg_right_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    shf_stage u_dut (
        .clk (clk), .rst (rst), .en (en), .data_in (data_in),
        .shift_op (shift_op), .cfg_sel (cfg_sel), .si_src_a (si_src_a),
        .si_src_b (si_src_b), .def_si (def_si), .msb_si_en (msb_si_en),
        .msb_pos (msb_pos), .out_sel (out_sel), .si_ext (si_ext),
        .chain_from_right (cfr), .chain_from_left (cfl),
        .data_out (data_out), .sh_left_out (sh_left_out),
        .sh_right_out (sh_right_out), .dp_shift_out (dp_shift_out),
        .reg_left_out (reg_left_out), .reg_right_out (reg_right_out)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [2:0] msb;
        logic [1:0] src;
        logic       dsi;
        logic       arith;
        logic       si;
        logic       cr;
        logic       cl;
        logic [7:0] d;
        logic [7:0] exp_d;
        logic       exp_sol;
        logic       exp_sor;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd7, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b1, 1'b1},
        '{2'd1, 3'd7, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h4B, 1'b1, 1'b1},
        '{2'd2, 3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h52, 1'b1, 1'b1},
        '{2'd2, 3'd7, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hD2, 1'b1, 1'b1},
        '{2'd1, 3'd7, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0},
        '{2'd2, 3'd5, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h24, 8'hB2, 1'b1, 1'b0},
        '{2'd1, 3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h24, 8'h49, 1'b1, 1'b0},
        '{2'd2, 3'd7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0, 1'b0},
        '{2'd3, 3'd7, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3, 1'b0, 1'b0},
        '{2'd0, 3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08, 8'h08, 1'b1, 1'b0},
        '{2'd1, 3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFE, 1'b1, 1'b1}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:       return "R1 pass";
            1:       return "R2 left default";
            2:       return "R3 right default";
            3:       return "R6 arithmetic right";
            4:       return "R6 msb option ignored on left";
            5:       return "R8 routed right, R3 upper group";
            6:       return "R9 chained left";
            7:       return "R9 chained right";
            8:       return "R10 swap ignores shift-in";
            9:       return "R4 pass shift-outs";
            default: return "R8 routed left";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic idle_inputs();
        en = 1'b0; cfg_sel = 1'b0; def_si = 1'b0; msb_si_en = 1'b0;
        out_sel = 1'b0; si_ext = 1'b0; cfr = 1'b0; cfl = 1'b0;
        data_in = 8'h00; shift_op = 2'd0; si_src_a = 2'd0; si_src_b = 2'd0;
        msb_pos = 3'd7;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R12 reset left reg", {7'd0, reg_left_out}, 8'd0);
        chk("R12 reset right reg", {7'd0, reg_right_out}, 8'd0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: combinational results, with en low so the registers stay 0
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            shift_op = VEC[i].op;
            msb_pos = VEC[i].msb;
            si_src_a = VEC[i].src;
            def_si = VEC[i].dsi;
            msb_si_en = VEC[i].arith;
            si_ext = VEC[i].si;
            cfr = VEC[i].cr;
            cfl = VEC[i].cl;
            data_in = VEC[i].d;
            out_sel = 1'b0;
            #1;
            chk(row_tag(i), data_out, VEC[i].exp_d);
            chk({row_tag(i), " R11 dp out right"}, {7'd0, dp_shift_out}, {7'd0, VEC[i].exp_sor});
            out_sel = 1'b1;
            #1;
            chk({row_tag(i), " R11 dp out left"}, {7'd0, dp_shift_out}, {7'd0, VEC[i].exp_sol});
            chk({row_tag(i), " R4 left out"}, {7'd0, sh_left_out}, {7'd0, VEC[i].exp_sol});
            chk({row_tag(i), " R4 right out"}, {7'd0, sh_right_out}, {7'd0, VEC[i].exp_sor});
        end

        // R5: set A selects default (0), set B selects routed (1)
        @(negedge clk);
        idle_inputs();
        shift_op = 2'd1; si_src_a = 2'd0; si_src_b = 2'd2; si_ext = 1'b1;
        cfg_sel = 1'b1;
        #1;
        chk("R5 set B routed", data_out, 8'h01);
        cfg_sel = 1'b0;
        #1;
        chk("R5 set A default", data_out, 8'h00);

        // R12 / R7: load left=0, right=1
        @(negedge clk);
        idle_inputs();
        en = 1'b1; data_in = 8'h01;
        @(posedge clk);
        #1;
        chk("R12 capture left", {7'd0, reg_left_out}, 8'd0);
        chk("R12 capture right", {7'd0, reg_right_out}, 8'd1);
        @(negedge clk);
        en = 1'b0; data_in = 8'h00; si_src_a = 2'd1; shift_op = 2'd1;
        #1;
        chk("R7 registered left", data_out, 8'h00);
        shift_op = 2'd2;
        #1;
        chk("R7 registered right", data_out, 8'h80);

        // R12 hold with en low
        @(negedge clk);
        data_in = 8'h80; shift_op = 2'd0;
        @(posedge clk);
        #1;
        chk("R12 hold left", {7'd0, reg_left_out}, 8'd0);
        chk("R12 hold right", {7'd0, reg_right_out}, 8'd1);

        // R12 update, then R7 sees the new value
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        #1;
        chk("R12 update left", {7'd0, reg_left_out}, 8'd1);
        chk("R12 update right", {7'd0, reg_right_out}, 8'd0);
        @(negedge clk);
        en = 1'b0; data_in = 8'h00; shift_op = 2'd1;
        #1;
        chk("R7 registered left after update", data_out, 8'h01);

        // R12 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R12 reset clears left", {7'd0, reg_left_out}, 8'd0);
        chk("R12 reset clears right", {7'd0, reg_right_out}, 8'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        finish_up();
    end

endmodule